// File: doc/BRIEF.md
# Framed Payload Nibble Clock Generator

This block times the transfer of transmit payload from terminal equipment that delivers four bits at a time. It tracks the bit position inside each outbound frame and issues one nibble clock pulse for every four payload bits. No pulse is issued while the frame is sending overhead bits. The terminal places a new nibble on the nibble pins at each rising edge of the nibble clock. The block captures that nibble when the clock falls and passes it to the framer on a valid/ready stream.

The block runs on one fast clock and moves forward one line bit at a time. It has two bit-enable inputs: one from the local transmit clock and one from the recovered receive line clock. The timing select input picks which enable drives the block. Three frame formats can be chosen, and a fourth code falls back to the first format. Changes to the format or the timing source are taken in only on a frame boundary, so the frame in progress always completes with its original geometry.

The payload stream cannot stall the line. `pay_valid` stays high until the framer asserts `pay_ready`. If the framer has not taken a nibble when the next one is captured, the new nibble replaces the old one. The framer therefore has four bit periods to accept each nibble.

Top module: `payload_nibble_clock`

## Requirements
- R1: Format code 0 gives a 4760-bit frame made of 56 groups of 85 bits. The first bit of each group is overhead, and the frame carries exactly 1176 nibble clock pulses.
- R2: Format code 1 gives a 4344-bit frame whose first 48 bits are overhead, and the frame carries exactly 1074 pulses.
- R3: Format code 2 gives a 1548-bit frame whose first 12 bits are overhead, and the frame carries exactly 384 pulses.
- R4: Format code 3 behaves exactly like format code 0.
- R5: Each issued slot holds `nib_clk` high for two bit periods and then low for two. No pulse covers an overhead bit. Two rising edges are always at least four bit periods apart, and across a group overhead bit they are exactly five apart.
- R6: With `loop_sel` = 0 the block advances only on `tx_bit_en`. With `loop_sel` = 1 it advances only on `rx_bit_en`. With no selected enable, no output changes.
- R7: `frame_start` is high for exactly the first bit period of each frame.
- R8: A change on `fmt_sel` or `loop_sel` takes effect only at the start of the next frame. The frame in progress keeps its length and its source.
- R9: On the bit where `nib_clk` falls, `nib_in` is captured. From the next clock onward, `pay_valid` is high and `pay_data` carries that nibble.
- R10: `pay_valid` stays high until `pay_ready` is seen high, and then drops on the following clock. A new capture replaces a nibble that has not been taken and keeps `pay_valid` high.
- R11: While `rst` is high, `nib_clk`, `frame_start` and `pay_valid` are low. The first frame begins at the first selected bit enable after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_bit_en | input | 1 | One-cycle bit enable from the local transmit clock |
| rx_bit_en | input | 1 | One-cycle bit enable from the recovered receive clock |
| fmt_sel | input | 2 | Frame format request (0, 3: 85-bit groups; 1: 48-bit header; 2: 12-bit header) |
| loop_sel | input | 1 | Timing source request (0 local, 1 loop) |
| nib_clk | output | 1 | Gated nibble clock toward the terminal |
| frame_start | output | 1 | High during bit 0 of each frame |
| nib_in | input | 4 | Payload nibble from the terminal |
| pay_valid | output | 1 | Captured nibble available |
| pay_data | output | 4 | Captured nibble |
| pay_ready | input | 1 | Framer accepts the nibble held on `pay_data` |

## Verification
Several properties are checked on every cycle: the minimum spacing of pulses, that outputs stay still without a selected enable, the one-bit width of `frame_start`, that the configuration changes only when a frame begins, and the capture and hold behaviour of the payload stream. Some results can only be shown over a whole frame, and the bench scenarios cover them. These are the exact pulse count and frame length for each format, the spacing of five bit periods across each group overhead bit, the doubled duration when the slower receive enable is selected, and the rule that the frame in progress finishes with its old settings after a change.

// File: rtl/pnc_pkg.sv
package pnc_pkg;
  typedef enum logic [1:0] {
    FMT_GRP85 = 2'd0,
    FMT_HDR48 = 2'd1,
    FMT_HDR12 = 2'd2,
    FMT_ALIAS = 2'd3
  } fmt_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pnc_slot_cnt.sv
module pnc_slot_cnt
  import pnc_pkg::*;
#(
  parameter int A_LEN = 85,
  parameter int A_GROUPS = 56,
  parameter int A_OH = 1,
  parameter int B_LEN = 4344,
  parameter int B_GROUPS = 1,
  parameter int B_OH = 48,
  parameter int C_LEN = 1548,
  parameter int C_GROUPS = 1,
  parameter int C_OH = 12,
  parameter int CNT_W = 13,
  parameter int GRP_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_bit_en,
  input  logic       rx_bit_en,
  input  logic [1:0] fmt_sel,
  input  logic       loop_sel,
  output logic       step,
  output logic       nxt_hi,
  output logic       nxt_fs,
  output logic [1:0] act_fmt,
  output logic       act_loop
);
  logic             started_q, loop_q, loop_n, load;
  fmt_e             fmt_q, fmt_n;
  logic [CNT_W-1:0] pos_q, pos_n, pay_off;
  logic [GRP_W-1:0] grp_q, grp_n;

  // Group length, group count and overhead per group for each format.
  function automatic logic [CNT_W-1:0] len_of(input fmt_e f);
    case (f)
      FMT_HDR48: len_of = CNT_W'(B_LEN);
      FMT_HDR12: len_of = CNT_W'(C_LEN);
      default:   len_of = CNT_W'(A_LEN);
    endcase
  endfunction

  function automatic logic [GRP_W-1:0] grp_of(input fmt_e f);
    case (f)
      FMT_HDR48: grp_of = GRP_W'(B_GROUPS);
      FMT_HDR12: grp_of = GRP_W'(C_GROUPS);
      default:   grp_of = GRP_W'(A_GROUPS);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] oh_of(input fmt_e f);
    case (f)
      FMT_HDR48: oh_of = CNT_W'(B_OH);
      FMT_HDR12: oh_of = CNT_W'(C_OH);
      default:   oh_of = CNT_W'(A_OH);
    endcase
  endfunction

  // Before the first frame, the requested source is used to start.
  assign step = started_q ? (loop_q ? rx_bit_en : tx_bit_en)
                          : (loop_sel ? rx_bit_en : tx_bit_en);

  always_comb begin
    load = !started_q ||
           ((pos_q == len_of(fmt_q) - 1'b1) && (grp_q == grp_of(fmt_q) - 1'b1));
    fmt_n  = load ? fmt_e'(fmt_sel) : fmt_q;
    loop_n = load ? loop_sel : loop_q;
    if (load) begin
      pos_n = '0;
      grp_n = '0;
    end else if (pos_q == len_of(fmt_q) - 1'b1) begin
      pos_n = '0;
      grp_n = grp_q + 1'b1;
    end else begin
      pos_n = pos_q + 1'b1;
      grp_n = grp_q;
    end
    pay_off = pos_n - oh_of(fmt_n);
    nxt_hi  = (pos_n >= oh_of(fmt_n)) && !pay_off[1];
    nxt_fs  = load;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      fmt_q     <= FMT_GRP85;
      loop_q    <= 1'b0;
      pos_q     <= '0;
      grp_q     <= '0;
    end else if (step) begin
      started_q <= 1'b1;
      fmt_q     <= fmt_n;
      loop_q    <= loop_n;
      pos_q     <= pos_n;
      grp_q     <= grp_n;
    end
  end

  assign act_fmt  = fmt_q;
  assign act_loop = loop_q;
endmodule

// File: rtl/pnc_pulse.sv
module pnc_pulse (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic nxt_hi,
  input  logic nxt_fs,
  output logic nib_clk,
  output logic frame_start,
  output logic fall_now
);
  logic nclk_q, fs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nclk_q <= 1'b0;
      fs_q   <= 1'b0;
    end else if (step) begin
      nclk_q <= nxt_hi;
      fs_q   <= nxt_fs;
    end
  end

  assign fall_now    = step && nclk_q && !nxt_hi;
  assign nib_clk     = nclk_q;
  assign frame_start = fs_q;
endmodule

// File: rtl/pnc_capture.sv
module pnc_capture #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_now,
  input  logic [NIB_W-1:0] nib_in,
  input  logic             pay_ready,
  output logic             pay_valid,
  output logic [NIB_W-1:0] pay_data
);
  logic             vld_q;
  logic [NIB_W-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (fall_now) begin
      vld_q <= 1'b1;
      dat_q <= nib_in;
    end else if (pay_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign pay_valid = vld_q;
  assign pay_data  = dat_q;
endmodule

// File: rtl/payload_nibble_clock.sv
module payload_nibble_clock
  import pnc_pkg::*;
#(
  parameter int GRP85_LEN    = 85,
  parameter int GRP85_GROUPS = 56,
  parameter int GRP85_OH     = 1,
  parameter int HDR48_LEN    = 4344,
  parameter int HDR48_GROUPS = 1,
  parameter int HDR48_OH     = 48,
  parameter int HDR12_LEN    = 1548,
  parameter int HDR12_GROUPS = 1,
  parameter int HDR12_OH     = 12,
  parameter int NIB_W        = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_bit_en,
  input  logic             rx_bit_en,
  input  logic [1:0]       fmt_sel,
  input  logic             loop_sel,
  output logic             nib_clk,
  output logic             frame_start,
  input  logic [NIB_W-1:0] nib_in,
  output logic             pay_valid,
  output logic [NIB_W-1:0] pay_data,
  input  logic             pay_ready
);
  localparam int CNT_W = $clog2(max3(GRP85_LEN, HDR48_LEN, HDR12_LEN) + 1);
  localparam int GRP_W = $clog2(max3(GRP85_GROUPS, HDR48_GROUPS, HDR12_GROUPS) + 1);

  logic       step, nxt_hi, nxt_fs, fall_now, act_loop;
  logic [1:0] act_fmt;

  pnc_slot_cnt #(
    .A_LEN(GRP85_LEN), .A_GROUPS(GRP85_GROUPS), .A_OH(GRP85_OH),
    .B_LEN(HDR48_LEN), .B_GROUPS(HDR48_GROUPS), .B_OH(HDR48_OH),
    .C_LEN(HDR12_LEN), .C_GROUPS(HDR12_GROUPS), .C_OH(HDR12_OH),
    .CNT_W(CNT_W), .GRP_W(GRP_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .tx_bit_en(tx_bit_en), .rx_bit_en(rx_bit_en),
    .fmt_sel(fmt_sel), .loop_sel(loop_sel), .step(step), .nxt_hi(nxt_hi),
    .nxt_fs(nxt_fs), .act_fmt(act_fmt), .act_loop(act_loop)
  );

  pnc_pulse u_pulse (
    .clk(clk), .rst(rst), .step(step), .nxt_hi(nxt_hi), .nxt_fs(nxt_fs),
    .nib_clk(nib_clk), .frame_start(frame_start), .fall_now(fall_now)
  );

  pnc_capture #(.NIB_W(NIB_W)) u_cap (
    .clk(clk), .rst(rst), .fall_now(fall_now), .nib_in(nib_in),
    .pay_ready(pay_ready), .pay_valid(pay_valid), .pay_data(pay_data)
  );
endmodule

// File: rtl/pnc_checker.sv
module pnc_checker #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             step,
  input logic             nib_clk,
  input logic             frame_start,
  input logic [NIB_W-1:0] nib_in,
  input logic             pay_valid,
  input logic [NIB_W-1:0] pay_data,
  input logic             pay_ready,
  input logic [1:0]       act_fmt,
  input logic             act_loop
);
  logic [2:0] gap_q;
  logic       nclk_d, rst_d;

  // Counts selected bit enables since the last observed rising nibble clock.
  always_ff @(posedge clk) begin
    rst_d  <= rst;
    nclk_d <= rst ? 1'b0 : nib_clk;
    if (rst) gap_q <= 3'd7;
    else if (nib_clk && !nclk_d) gap_q <= step ? 3'd1 : 3'd0;
    else if (step && gap_q != 3'd7) gap_q <= gap_q + 3'd1;
  end

  p_min_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(nib_clk) |-> gap_q >= 3'd4);

  p_step_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(nib_clk) && $stable(frame_start));

  p_fs_one_bit_r7: assert property (@(posedge clk) disable iff (rst)
    frame_start && step |=> !frame_start);

  p_cfg_at_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable({act_fmt, act_loop}) |-> frame_start);

  p_capture_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(nib_clk) |-> pay_valid && (pay_data == $past(nib_in)));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    pay_valid && !pay_ready |=> pay_valid);

  always @(negedge clk) begin
    if (rst_d) begin
      p_reset_state_r11: assert (!nib_clk && !frame_start && !pay_valid);
    end
  end
endmodule

bind payload_nibble_clock pnc_checker u_chk (
  .clk(clk), .rst(rst), .step(step), .nib_clk(nib_clk),
  .frame_start(frame_start), .nib_in(nib_in), .pay_valid(pay_valid),
  .pay_data(pay_data), .pay_ready(pay_ready), .act_fmt(act_fmt),
  .act_loop(act_loop)
);

// File: tb/tb_payload_nibble_clock.sv
module tb_payload_nibble_clock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_bit_en = 1'b1;
  logic       rx_bit_en = 1'b0;
  logic       loop_sel = 1'b0;
  logic       pay_ready = 1'b1;
  logic [1:0] fmt_sel = 2'd0;
  logic [3:0] nib_in = 4'd0;
  logic       nib_clk, frame_start, pay_valid;
  logic [3:0] pay_data;

  int n_chk = 0;
  int n_err = 0;
  logic last_nclk = 1'b0;
  logic last_fs = 1'b0;
  bit nrise, nfall, frise;

  // fmt, loop, pulses per frame, clock cycles per frame, five-bit gaps
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{0, 0, 1176, 4760, 55},
    '{1, 1, 1074, 8688, 0},
    '{2, 0, 384, 1548, 0},
    '{2, 1, 384, 3096, 0},
    '{3, 0, 1176, 4760, 55},
    '{0, 1, 1176, 9520, 55},
    '{1, 0, 1074, 4344, 0}
  };

  always #4 clk = ~clk;

  payload_nibble_clock dut (
    .clk(clk), .rst(rst), .tx_bit_en(tx_bit_en), .rx_bit_en(rx_bit_en),
    .fmt_sel(fmt_sel), .loop_sel(loop_sel), .nib_clk(nib_clk),
    .frame_start(frame_start), .nib_in(nib_in), .pay_valid(pay_valid),
    .pay_data(pay_data), .pay_ready(pay_ready)
  );

  // Receive enable runs at half rate, transmit enable at full rate.
  initial forever begin
    @(negedge clk);
    rx_bit_en = ~rx_bit_en;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    nrise = nib_clk && !last_nclk;
    nfall = !nib_clk && last_nclk;
    frise = frame_start && !last_fs;
    last_nclk = nib_clk;
    last_fs = frame_start;
  endtask

  task automatic measure(output int cyc, output int pul, output int g5,
                         output int gmin, output int fsh, input int wide);
    int since;
    bit seen;
    cyc = 0; pul = 0; g5 = 0; gmin = 1000000; fsh = 1; since = 0; seen = 0;
    forever begin
      tick();
      cyc++;
      if (frise) break;
      if (frame_start) fsh++;
      since++;
      if (nrise) begin
        pul++;
        if (seen) begin
          if (since < gmin) gmin = since;
          if (since == 5 * wide) g5++;
        end
        seen = 1;
        since = 0;
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int cyc, pul, g5, gmin, fsh, prev, wide;
    string rq;
    repeat (4) @(negedge clk);
    check(!nib_clk, "R11 nib_clk low in reset", nib_clk, 0);
    check(!frame_start, "R11 frame_start low in reset", frame_start, 0);
    check(!pay_valid, "R11 pay_valid low in reset", pay_valid, 0);
    rst = 1'b0;
    tick();
    check(frise, "R11 first frame on first enable", frame_start, 1);
    prev = VEC[0][3];

    for (int i = 0; i < NV; i++) begin
      fmt_sel  = 2'(VEC[i][0]);
      loop_sel = VEC[i][1] != 0;
      wide     = VEC[i][1] + 1;
      rq = (VEC[i][0] == 1) ? "R2" : (VEC[i][0] == 2) ? "R3" :
           (VEC[i][0] == 3) ? "R4" : "R1";
      measure(cyc, pul, g5, gmin, fsh, wide);
      check(cyc == prev, "R8 frame in progress keeps old settings", cyc, prev);
      measure(cyc, pul, g5, gmin, fsh, wide);
      check(pul == VEC[i][2], {rq, " pulses per frame"}, pul, VEC[i][2]);
      check(cyc == VEC[i][3] || (wide == 2 && cyc == VEC[i][3] - 1),
            "R6 frame duration follows selected enable", cyc, VEC[i][3]);
      check(g5 == VEC[i][4], "R5 gaps across group overhead", g5, VEC[i][4]);
      check(gmin == 4 * wide, "R5 minimum pulse spacing", gmin, 4 * wide);
      if (wide == 1) check(fsh == 1, "R7 frame_start one bit wide", fsh, 1);
      prev = VEC[i][3];
    end

    // Directed: capture on the falling edge with the stream always ready.
    for (int k = 0; k < 40; k++) begin
      do tick(); while (!nrise);
      nib_in = 4'(k * 7 + 3);
      do tick(); while (!nfall);
      check(pay_valid && pay_data == nib_in, "R9 nibble captured on fall",
            pay_data, nib_in);
      tick();
      check(!pay_valid, "R10 valid drops after accept", pay_valid, 0);
    end

    // Directed: back-pressure and overwrite of an untaken nibble.
    pay_ready = 1'b0;
    do tick(); while (!nrise);
    nib_in = 4'hA;
    do tick(); while (!nfall);
    check(pay_valid && pay_data == 4'hA, "R9 capture under back-pressure", pay_data, 10);
    tick();
    tick();
    check(pay_valid && pay_data == 4'hA, "R10 nibble held while not ready", pay_data, 10);
    do tick(); while (!nrise);
    nib_in = 4'h3;
    do tick(); while (!nfall);
    check(pay_valid && pay_data == 4'h3, "R10 untaken nibble replaced", pay_data, 3);
    pay_ready = 1'b1;
    tick();
    check(!pay_valid, "R10 release after ready", pay_valid, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule